// File: doc/BRIEF.md
# Write-Protection Key Sequence Guard

The guard sits between the host write strobe and the page-load controller of a parallel nonvolatile memory array. For every write strobe it looks at the address and data byte and matches them against two key sequences: a three-byte arming key and a six-byte disarming key. Bytes that advance a key are consumed as command bytes and never reach the array. The guard keeps a protection flag. Once the flag is set, an ordinary page load reaches the array only if the arming key directly precedes it. Any other write is turned into a timed no-op: the controller runs its write timer, but nothing is stored.

Each byte of a key must arrive within a load window of `GAP_LIMIT` clock cycles after the previous strobe, the same limit that bounds page loading. A stale partial key is dropped. Protection changes only when the controller reports the end of a write period (`cyc_done`) after a completed key. If a key completes and no data byte follows before the window closes, the guard issues one no-op start, so that the write period still runs and the pending change takes effect. All strobe results come out one clock after the strobe, together with the echoed address and data.

Top module: `wps_guard`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `prot_on`, `out_stb`, `key_byte` and `sink_start` are all 0.
- R2: The arming key is data 8'hAA to address 13'h1555, then 8'h55 to 13'h0AAA, then 8'hA0 to 13'h1555. Each of these three strobes gives `key_byte`=1 and `out_stb`=0.
- R3: `prot_on` changes only in the cycle after a `cyc_done` pulse. At the first `cyc_done` after a completed arming key it becomes 1. It does not change when the key completes.
- R4: The disarming key is 8'hAA@13'h1555, 8'h55@13'h0AAA, 8'h80@13'h1555, 8'hAA@13'h1555, 8'h55@13'h0AAA, 8'h20@13'h1555. Every byte is a command byte. At the next `cyc_done`, `prot_on` becomes 0.
- R5: With `prot_on`=1, a write that is not part of a key and does not follow a completed key in the same load window gives `sink_start`=1 and `out_stb`=0.
- R6: With `prot_on`=1, data bytes that follow a completed arming key within the load window give `out_stb`=1.
- R7: A strobe that does not match the next expected key byte drops the partial key and is handled as an ordinary write. If that strobe is 8'hAA@13'h1555, it starts a new key as a command byte.
- R8: A strobe that arrives GAP_LIMIT or fewer cycles after the previous strobe stays in the same load window. A longer gap closes the window, so a key continuation byte that arrives after the gap is handled as an ordinary write.
- R9: A completed key followed by no data byte before the window closes gives exactly one `sink_start` pulse when the window closes, with no strobe pending.
- R10: The key addresses accept ordinary data outside a key, for example 8'h55@13'h1555 passes when protection is off.
- R11: At most one of `out_stb`, `key_byte` and `sink_start` is high in any cycle. The results appear one cycle after the strobe, and `out_addr`/`out_data` echo the strobed address and data with `out_stb`.
- R12: A `cyc_done` pulse with no completed key since the previous one leaves `prot_on` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_addr | input | AW | Address of the write |
| wr_data | input | 8 | Data byte of the write |
| cyc_done | input | 1 | Pulse from the controller at the end of a write period |
| out_stb | output | 1 | Filtered strobe: store this byte in the page buffer |
| out_addr | output | AW | Address for the filtered strobe |
| out_data | output | 8 | Data for the filtered strobe |
| key_byte | output | 1 | The strobe was consumed as a command byte |
| sink_start | output | 1 | Start the write timer but store nothing |
| prot_on | output | 1 | Current protection flag |

## Verification
On every cycle the checker enforces that the three strobe results exclude each other. It also checks that they trace back to a strobe one cycle earlier, that forwarded bytes carry the strobed address and data, that the flag moves only after `cyc_done`, and the state in and right after reset. Whether a particular byte is consumed, passed or sunk depends on the history of keys, gaps and the flag, so only the bench scenarios can show it. These are a sweep of every third-byte value after a partial key, windows that are one cycle inside and one cycle outside the gap limit, aborted and restarted keys, and the single no-op pulse for a key-only load.

// File: rtl/wps_pkg.sv
// Package: shared types and key byte values of the write-protection guard.
// Assumes one write strobe per load slot; key addresses are top parameters.
package wps_pkg;

    // Progress through the key sequences; ST_OPEN means a key completed
    // and the current load window accepts authorised data.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_K1   = 3'd1,
        ST_K2   = 3'd2,
        ST_D3   = 3'd3,
        ST_D4   = 3'd4,
        ST_D5   = 3'd5,
        ST_OPEN = 3'd6
    } seq_st_t;

    // Result class of one strobe.
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_PASS = 2'd1,
        CLS_KEY  = 2'd2,
        CLS_SINK = 2'd3
    } cls_t;

    // Protection change requested by a completed key.
    typedef enum logic [1:0] {
        REQ_NONE   = 2'd0,
        REQ_ARM    = 2'd1,
        REQ_DISARM = 2'd2
    } req_t;

    localparam logic [7:0] KD_LEAD   = 8'hAA;
    localparam logic [7:0] KD_SECOND = 8'h55;
    localparam logic [7:0] KD_ARM    = 8'hA0;
    localparam logic [7:0] KD_ESC    = 8'h80;
    localparam logic [7:0] KD_DISARM = 8'h20;

endpackage

// File: rtl/wps_gap_timer.sv
// Module: load-window timer. Counts idle cycles since the last strobe and
// flags the window as closed once LIMIT idle cycles have passed.
// Assumes LIMIT >= 1. Counter saturates; reset leaves the window closed.
module wps_gap_timer #(
    parameter int LIMIT = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CMAX = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Restart on each strobe, otherwise count up to the limit and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CMAX;
        end else if (stb) begin
            cnt_q <= '0;
        end else if (cnt_q != CMAX) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Window is closed once the count has reached its limit.
    always_comb begin
        expired = (cnt_q == CMAX);
    end
endmodule

// File: rtl/wps_key_matcher.sv
// Module: key sequence matcher. Tracks progress through the arming and
// disarming keys, classifies each strobe and requests protection changes.
// Assumes 'expired' comes from the load-window timer, sampled before the
// timer sees the current strobe. A strobe in a closed window starts fresh.
module wps_key_matcher
    import wps_pkg::*;
#(
    parameter int AW = 13,
    parameter logic [AW-1:0] KEY_A = AW'(13'h1555),
    parameter logic [AW-1:0] KEY_B = AW'(13'h0AAA)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    data,
    input  logic          expired,
    input  logic          prot,
    output cls_t          cls,
    output req_t          req,
    output logic          tail_sink
);
    seq_st_t st_q, st_d, st_e;
    logic    got_q, got_d;
    logic    at_a, at_b, lead_hit;
    cls_t    plain_cls;

    // Decode the address/data pair against the key bytes.
    always_comb begin
        at_a      = (addr == KEY_A);
        at_b      = (addr == KEY_B);
        lead_hit  = at_a && (data == KD_LEAD);
        plain_cls = prot ? CLS_SINK : CLS_PASS;
        st_e      = expired ? ST_IDLE : st_q;
    end

    // Next state, strobe class and change request.
    always_comb begin
        st_d      = st_q;
        got_d     = got_q;
        cls       = CLS_NONE;
        req       = REQ_NONE;
        tail_sink = 1'b0;
        if (stb) begin
            // default: mismatch, drop partial key; restart on a lead byte
            st_d = lead_hit ? ST_K1 : ST_IDLE;
            cls  = lead_hit ? CLS_KEY : plain_cls;
            unique case (st_e)
                ST_IDLE: ;
                ST_K1: begin
                    if (at_b && data == KD_SECOND) begin
                        st_d = ST_K2;
                        cls  = CLS_KEY;
                    end
                end
                ST_K2: begin
                    if (at_a && data == KD_ARM) begin
                        st_d  = ST_OPEN;
                        got_d = 1'b0;
                        cls   = CLS_KEY;
                        req   = REQ_ARM;
                    end else if (at_a && data == KD_ESC) begin
                        st_d = ST_D3;
                        cls  = CLS_KEY;
                    end
                end
                ST_D3: begin
                    if (lead_hit) begin
                        st_d = ST_D4;
                        cls  = CLS_KEY;
                    end
                end
                ST_D4: begin
                    if (at_b && data == KD_SECOND) begin
                        st_d = ST_D5;
                        cls  = CLS_KEY;
                    end
                end
                ST_D5: begin
                    if (at_a && data == KD_DISARM) begin
                        st_d  = ST_OPEN;
                        got_d = 1'b0;
                        cls   = CLS_KEY;
                        req   = REQ_DISARM;
                    end
                end
                ST_OPEN: begin
                    st_d  = ST_OPEN;
                    got_d = 1'b1;
                    cls   = CLS_PASS;
                end
                default: ;
            endcase
        end else if (expired && st_q != ST_IDLE) begin
            // window closed with no strobe: drop state, run key-only period
            st_d      = ST_IDLE;
            tail_sink = (st_q == ST_OPEN) && !got_q;
        end
    end

    // Sequence state and the data-seen flag of an open window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            got_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            got_q <= got_d;
        end
    end
endmodule

// File: rtl/wps_prot_state.sv
// Module: protection flag keeper. Holds the latest key request and applies
// it at the end of the next write period.
// Assumes at most one request per cycle; the newest request replaces an
// older pending one.
module wps_prot_state
    import wps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  req_t req,
    input  logic cyc_done,
    output logic prot
);
    req_t pend_q;
    logic prot_q;

    // Pending request: replaced by a new one, consumed at period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= REQ_NONE;
        end else if (req != REQ_NONE) begin
            pend_q <= req;
        end else if (cyc_done) begin
            pend_q <= REQ_NONE;
        end
    end

    // Flag update at the end of a write period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
        end else if (cyc_done) begin
            if (pend_q == REQ_ARM) begin
                prot_q <= 1'b1;
            end else if (pend_q == REQ_DISARM) begin
                prot_q <= 1'b0;
            end
        end
    end

    // Drive the flag out.
    always_comb begin
        prot = prot_q;
    end
endmodule

// File: rtl/wps_guard.sv
// Module: write-protection key sequence guard (top). Filters host write
// strobes for the page-load controller: key bytes are consumed, authorised
// or unprotected data is forwarded, unauthorised writes become timed no-ops.
// Assumes single-cycle strobes and a one-cycle cyc_done pulse per period.
// All strobe results are registered: one cycle of latency.
module wps_guard
    import wps_pkg::*;
#(
    parameter int AW        = 13,
    parameter int GAP_LIMIT = 30000,
    parameter logic [AW-1:0] KEY_A = AW'(13'h1555),
    parameter logic [AW-1:0] KEY_B = AW'(13'h0AAA)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          cyc_done,
    output logic          out_stb,
    output logic [AW-1:0] out_addr,
    output logic [7:0]    out_data,
    output logic          key_byte,
    output logic          sink_start,
    output logic          prot_on
);
    logic expired;
    logic prot;
    logic tail_sink;
    cls_t cls;
    req_t req;

    wps_gap_timer #(
        .LIMIT (GAP_LIMIT)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (wr_stb),
        .expired (expired)
    );

    wps_key_matcher #(
        .AW    (AW),
        .KEY_A (KEY_A),
        .KEY_B (KEY_B)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (wr_stb),
        .addr      (wr_addr),
        .data      (wr_data),
        .expired   (expired),
        .prot      (prot),
        .cls       (cls),
        .req       (req),
        .tail_sink (tail_sink)
    );

    wps_prot_state u_prot (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .cyc_done (cyc_done),
        .prot     (prot)
    );

    // Output stage: one registered result per strobe or window close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_stb    <= 1'b0;
            key_byte   <= 1'b0;
            sink_start <= 1'b0;
            out_addr   <= '0;
            out_data   <= '0;
        end else begin
            out_stb    <= (cls == CLS_PASS);
            key_byte   <= (cls == CLS_KEY);
            sink_start <= (cls == CLS_SINK) || tail_sink;
            out_addr   <= wr_addr;
            out_data   <= wr_data;
        end
    end

    // Flag is registered inside the keeper; expose it directly.
    always_comb begin
        prot_on = prot;
    end
endmodule

// File: rtl/wps_guard_chk.sv
// Module: property checker for wps_guard, attached with bind.
// Assumes the same parameterisation as the instance it is bound to.
module wps_guard_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_stb,
    input logic [AW-1:0] wr_addr,
    input logic [7:0]    wr_data,
    input logic          cyc_done,
    input logic          out_stb,
    input logic [AW-1:0] out_addr,
    input logic [7:0]    out_data,
    input logic          key_byte,
    input logic          sink_start,
    input logic          prot_on
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!prot_on && !out_stb && !key_byte && !sink_start)); // R1

    AST_FLAG_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_done |=> $stable(prot_on)); // R3

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_stb, key_byte, sink_start})); // R11

    AST_RESULT_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb || key_byte) |-> $past(wr_stb)); // R11

    AST_ECHO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |-> (out_addr == $past(wr_addr) && out_data == $past(wr_data))); // R11
endmodule

bind wps_guard wps_guard_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cyc_done   (cyc_done),
    .out_stb    (out_stb),
    .out_addr   (out_addr),
    .out_data   (out_data),
    .key_byte   (key_byte),
    .sink_start (sink_start),
    .prot_on    (prot_on)
);

// File: tb/sim_wps_guard.sv
module sim_wps_guard;
    localparam int AW  = 13;
    localparam int GAP = 8;
    localparam logic [AW-1:0] KA = 13'h1555;
    localparam logic [AW-1:0] KB = 13'h0AAA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          cyc_done = 1'b0;
    logic          out_stb, key_byte, sink_start, prot_on;
    logic [AW-1:0] out_addr;
    logic [7:0]    out_data;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int sink_cnt, pass_cnt;

    always #2.5 clk = ~clk;

    wps_guard #(.AW(AW), .GAP_LIMIT(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .cyc_done(cyc_done), .out_stb(out_stb),
        .out_addr(out_addr), .out_data(out_data), .key_byte(key_byte),
        .sink_start(sink_start), .prot_on(prot_on)
    );

    // watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // result of a strobe packed as {pass, key, sink}
    function automatic logic [2:0] res();
        return {out_stb, key_byte, sink_start};
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // idle cycles counting stray results
    task automatic idle_count(input int n);
        sink_cnt = 0; pass_cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sink_cnt = sink_cnt + int'(sink_start);
            pass_cnt = pass_cnt + int'(out_stb) + int'(key_byte);
        end
    endtask

    task automatic pulse_done();
        cyc_done = 1'b1;
        @(negedge clk);
        cyc_done = 1'b0;
    endtask

    task automatic arm_key(input string req);
        wr(KA, 8'hAA); check(req, res(), 3'b010);
        wr(KB, 8'h55); check(req, res(), 3'b010);
        wr(KA, 8'hA0); check(req, res(), 3'b010);
    endtask

    initial begin
        @(negedge clk);
        check("R1 reset", {29'd0, res()}, 32'd0);
        check("R1 reset prot", prot_on, 1'b0);
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {28'd0, prot_on, res()}, 32'd0);

        // unprotected ordinary write, echoed
        wr(13'h0100, 8'h33);
        check("R11 pass", res(), 3'b100);
        check("R11 echo addr", out_addr, 13'h0100);
        check("R11 echo data", out_data, 8'h33);
        idle(1);
        check("R11 single cycle", res(), 3'b000);

        // key addresses take plain data
        wr(KA, 8'h55); check("R10 data at key addr", res(), 3'b100);
        wr(KB, 8'hAA); check("R10 data at key addr b", res(), 3'b100);
        idle(GAP + 2);

        // arm: keys consumed, flag waits for period end
        arm_key("R2 arm key byte");
        check("R3 no change at key", prot_on, 1'b0);
        wr(13'h0040, 8'h5A); check("R6 data after key", res(), 3'b100);
        idle(GAP + 2);
        check("R3 no change before done", prot_on, 1'b0);
        pulse_done();
        check("R3 flag set at done", prot_on, 1'b1);
        pulse_done();
        check("R12 idle done keeps flag", prot_on, 1'b1);

        // unauthorised write
        wr(13'h0020, 8'h11); check("R5 sink", res(), 3'b001);
        idle(GAP + 2);

        // gap inside the window
        wr(KA, 8'hAA); idle(GAP - 1);
        wr(KB, 8'h55); check("R8 in window", res(), 3'b010);
        idle(GAP - 1);
        wr(KA, 8'hA0); check("R8 in window arm", res(), 3'b010);
        idle(GAP - 1);
        wr(13'h0041, 8'h77); check("R8 R6 data in window", res(), 3'b100);
        idle(GAP + 2);
        // gap one cycle too long
        wr(KA, 8'hAA); idle(GAP);
        wr(KB, 8'h55); check("R8 out of window", res(), 3'b001);
        idle(GAP + 2);

        // key-only load: one no-op at window close
        arm_key("R9 key bytes");
        idle_count(3 * GAP);
        check("R9 one sink", sink_cnt, 1);
        check("R9 nothing else", pass_cnt, 0);

        // abort and restart
        wr(KA, 8'hAA); wr(KB, 8'h55);
        wr(KA, 8'hAA); check("R7 restart lead", res(), 3'b010);
        wr(KB, 8'h55); check("R7 restarted second", res(), 3'b010);
        wr(KA, 8'hA0); check("R7 restarted arm", res(), 3'b010);
        wr(13'h0042, 8'h01); check("R7 data after restart", res(), 3'b100);
        idle(GAP + 2);
        wr(KA, 8'hAA);
        wr(KB, 8'h12); check("R7 mismatch sinks", res(), 3'b001);
        idle(GAP + 2);

        // disarm
        wr(KA, 8'hAA); check("R4 d1", res(), 3'b010);
        wr(KB, 8'h55); check("R4 d2", res(), 3'b010);
        wr(KA, 8'h80); check("R4 d3", res(), 3'b010);
        wr(KA, 8'hAA); check("R4 d4", res(), 3'b010);
        wr(KB, 8'h55); check("R4 d5", res(), 3'b010);
        wr(KA, 8'h20); check("R4 d6", res(), 3'b010);
        check("R4 flag held until done", prot_on, 1'b1);
        idle(GAP + 2);
        pulse_done();
        check("R4 flag cleared", prot_on, 1'b0);
        wr(13'h0005, 8'hC3); check("R4 plain passes", res(), 3'b100);
        idle(GAP + 2);

        // re-arm, then sweep every third byte after a partial key
        arm_key("R2 rearm");
        idle(GAP + 2);
        pulse_done();
        check("R3 rearmed", prot_on, 1'b1);
        for (int d = 0; d < 256; d++) begin
            logic [2:0] e3, ex;
            e3 = (d == 'hA0 || d == 'h80 || d == 'hAA) ? 3'b010 : 3'b001;
            ex = (d == 'hA0) ? 3'b100 : 3'b001;
            wr(KA, 8'hAA); check("R2 sweep lead", res(), 3'b010);
            wr(KB, 8'h55); check("R2 sweep second", res(), 3'b010);
            wr(KA, 8'(d)); check("R7 sweep third", res(), e3);
            wr(13'h0010, 8'(d)); check("R6 R5 sweep data", res(), ex);
            idle(GAP + 2);
        end
        check("R12 flag after sweep", prot_on, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule